// File: doc/BRIEF.md
# Periodic Entropy Word Queue

This block keeps a small queue of 64-bit random words so that a host read nearly always finds one waiting. An internal interval counter produces a sampling tick every fixed number of cycles. On each tick, if the external entropy source reports a valid word, that word is appended to the queue. When the queue is full the word is quietly discarded.

The host reaches the block through a single-cycle request port. One half of the word-address space is a queue window. Every address in that window refers to the queue head, so any read there removes one word. A write into the window stores nothing and is recorded as an addressing error. The other half of the address space holds three registers: a sticky interrupt-status register cleared by writing ones, an interrupt mask, and a go register that accepts writes and does nothing. Read data comes back one cycle after the request, together with a valid strobe.

Top module: `entq_top`

## Requirements
- R1: After reset, the queue is empty, the status and mask registers read 0, and both `irq` and `rsp_valid` are low.
- R2: The interval counter restarts at reset. It ticks at every `SAMPLE_PERIOD`-th rising edge after reset release. On a tick where `src_valid` is high, `src_data` is appended to the queue. No word is appended at other edges, or on a tick where `src_valid` is low.
- R3: The window is every address with bit `AW-1` set. A read anywhere in the window removes the head word. The next cycle shows `rsp_valid` high and that word on `rsp_rdata`, and words come out in arrival order.
- R4: A window read while the queue is empty returns all zeros and sets status bit 0 (underflow).
- R5: A window write sets status bit 1 (address error) and leaves the queue contents and order unchanged.
- R6: A sample ticked while the queue is full is dropped, and no status bit is set.
- R7: When a window read and a sample append fall in the same cycle on a queue that is neither empty nor full, both take effect.
- R8: Status bits stay set until cleared. Writing to register address 0 clears exactly the status bits whose data bit is 1. Reading address 0 returns the status in bits 1:0.
- R9: Register address 1 holds a 2-bit mask, and a mask bit of 1 masks that status bit. `irq` is high exactly when some status bit is set with its mask bit 0.
- R10: Register address 2 (go) accepts writes with no effect and reads 0. Outside the window, an address whose bits `AW-2:2` are not all zero, or whose low two bits are 3, reads 0 and ignores writes.
- R11: The queue holds exactly `DEPTH` words. With `DEPTH` words stored and sampling stopped, `DEPTH` reads return them and the next read underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | 1 | Entropy word on `src_data` is usable |
| src_data | input | DATA_W | Entropy word |
| req_valid | input | 1 | Host request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | DATA_W | Read data |
| irq | output | 1 | Some unmasked status bit is set |

## Verification
The critical overlap is a host pop of the head landing in the same cycle as a sampling tick's append, including the edge cases where the queue is full (the append must be lost) or empty (the read must underflow while the append still lands). The bench issues back-to-back reads across the whole address space while sampling runs with a period of 5, so the read stream slides past the ticks and reaches every relative phase. Each returned word is judged against a queue model in the bench that applies the pop before the append in every cycle, and the bench also confirms that the overlap case actually occurred.

// File: rtl/entq_pkg.sv
package entq_pkg;

  // register selector inside the non-window half of the address space
  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_MASK = 2'd1,
    REG_GO   = 2'd2,
    REG_RSVD = 2'd3
  } entq_reg_e;

  localparam int ST_UFL  = 0;
  localparam int ST_AERR = 1;
  localparam int ST_W    = 2;

endpackage

// File: rtl/entq_sampler.sv
module entq_sampler #(
  parameter int SAMPLE_PERIOD = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int CW = (SAMPLE_PERIOD > 1) ? $clog2(SAMPLE_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(SAMPLE_PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (SAMPLE_PERIOD > 1) begin : g_spacing
      // R2: ticks never come on adjacent cycles
      a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/entq_fifo.sv
module entq_fifo #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full,
  output logic [$clog2(DEPTH):0] level
);

  localparam int PW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW:0] wr_ptr_q, wr_ptr_d;
  logic [PW:0] rd_ptr_q, rd_ptr_d;
  logic        do_push, do_pop;

  always_comb begin
    empty    = (wr_ptr_q == rd_ptr_q);
    full     = (wr_ptr_q[PW] != rd_ptr_q[PW]) &&
               (wr_ptr_q[PW-1:0] == rd_ptr_q[PW-1:0]);
    do_push  = push_req && !full;
    do_pop   = pop_req && !empty;
    wr_ptr_d = do_push ? wr_ptr_q + 1'b1 : wr_ptr_q;
    rd_ptr_d = do_pop  ? rd_ptr_q + 1'b1 : rd_ptr_q;
    head     = mem[rd_ptr_q[PW-1:0]];
    level    = wr_ptr_q - rd_ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q[PW-1:0]] <= push_data;
  end

  a_r11_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (PW+1)'(DEPTH));

  a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop_req) |=> (level == $past(level)));

  a_r7_push_pop_same: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req && !empty && !full) |=> (level == $past(level)));

  a_r3_pop_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !empty && !push_req) |=> (level == $past(level) - 1'b1));

endmodule

// File: rtl/entq_regs.sv
module entq_regs
  import entq_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] fifo_head,
  input  logic              fifo_empty,
  output logic              pop,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq
);

  logic [ST_W-1:0]   status_q, status_d;
  logic [ST_W-1:0]   mask_q, mask_d;
  logic              rsp_valid_d;
  logic [DATA_W-1:0] rsp_rdata_d;
  logic              in_win, reg_ok, rd, wr;
  logic              stat_wr, mask_wr;
  logic [ST_W-1:0]   set_bits, clr_bits;
  entq_reg_e         sel;
  logic              unused_wdata;

  assign unused_wdata = ^req_wdata[DATA_W-1:ST_W];

  always_comb begin
    in_win  = req_addr[AW-1];
    reg_ok  = !in_win && (req_addr[AW-2:2] == '0);
    sel     = entq_reg_e'(req_addr[1:0]);
    rd      = req_valid && !req_write;
    wr      = req_valid && req_write;
    pop     = rd && in_win;
    stat_wr = wr && reg_ok && (sel == REG_STAT);
    mask_wr = wr && reg_ok && (sel == REG_MASK);

    set_bits          = '0;
    set_bits[ST_UFL]  = pop && fifo_empty;
    set_bits[ST_AERR] = wr && in_win;
    clr_bits          = stat_wr ? req_wdata[ST_W-1:0] : '0;
    status_d          = (status_q & ~clr_bits) | set_bits;
    mask_d            = mask_wr ? req_wdata[ST_W-1:0] : mask_q;

    rsp_valid_d = rd;
    rsp_rdata_d = '0;
    if (in_win) begin
      if (!fifo_empty) rsp_rdata_d = fifo_head;
    end else if (reg_ok) begin
      case (sel)
        REG_STAT: rsp_rdata_d[ST_W-1:0] = status_q;
        REG_MASK: rsp_rdata_d[ST_W-1:0] = mask_q;
        default:  rsp_rdata_d = '0;
      endcase
    end

    irq = |(status_q & ~mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= '0;
      mask_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      status_q  <= status_d;
      mask_q    <= mask_d;
      rsp_valid <= rsp_valid_d;
      if (rd) rsp_rdata <= rsp_rdata_d;
    end
  end

  a_r4_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && fifo_empty) |=> status_q[ST_UFL]);

  a_r4_underflow_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && fifo_empty) |=> (rsp_rdata == '0));

  a_r5_addr_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && in_win) |=> status_q[ST_AERR]);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[ST_UFL] && !(stat_wr && req_wdata[ST_UFL])) |=> status_q[ST_UFL]);

endmodule

// File: rtl/entq_top.sv
module entq_top #(
  parameter int DATA_W        = 64,
  parameter int DEPTH         = 8,
  parameter int SAMPLE_PERIOD = 5,
  parameter int AW            = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq
);

  localparam int PW = $clog2(DEPTH);

  logic              tick;
  logic              push_req;
  logic              pop;
  logic [DATA_W-1:0] head;
  logic              empty, full;
  logic [PW:0]       level;

  entq_sampler #(.SAMPLE_PERIOD(SAMPLE_PERIOD)) u_sampler (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  assign push_req = tick && src_valid;

  entq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (push_req),
    .push_data (src_data),
    .pop_req   (pop),
    .head      (head),
    .empty     (empty),
    .full      (full),
    .level     (level)
  );

  entq_regs #(.DATA_W(DATA_W), .AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .fifo_head  (head),
    .fifo_empty (empty),
    .pop        (pop),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .irq        (irq)
  );

  a_r5_write_keeps_queue: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[AW-1] && !push_req) |=> (level == $past(level)));

  a_r2_no_push_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !pop) |=> (level == $past(level)));

endmodule

// File: tb/tb_entq_top.sv
`timescale 1ns/1ps
module tb_entq_top;

  localparam int DW    = 64;
  localparam int DEPTH = 8;
  localparam int P     = 5;
  localparam int AW    = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          src_valid;
  logic [DW-1:0] src_data;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          irq;

  entq_top #(.DATA_W(DW), .DEPTH(DEPTH), .SAMPLE_PERIOD(P), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq(irq)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int both_cnt = 0;

  function automatic void chk(input string tag, input logic [DW-1:0] act,
                              input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endfunction

  // entropy pattern, refreshed away from the active edge
  always @(negedge clk) begin
    cyc++;
    src_data = {32'hA5A5_0000 ^ 32'(cyc), 32'(cyc) * 32'h9E37_79B9};
  end

  // queue model built from the requirements
  logic [DW-1:0] mq [DEPTH];
  int            mhead, mcount, mtc;
  logic [1:0]    mstat, mmask;
  logic [DW-1:0] exp_rd;
  logic          m_tick, m_push, m_win, m_ok;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mhead = 0; mcount = 0; mtc = 0; mstat = 0; mmask = 0; exp_rd = '0;
    end else begin
      m_tick = (mtc == P - 1);
      mtc    = m_tick ? 0 : mtc + 1;
      m_push = m_tick && src_valid && (mcount < DEPTH);
      m_win  = req_addr[AW-1];
      m_ok   = !m_win && (req_addr[AW-2:2] == '0);
      if (req_valid && !req_write) begin
        if (m_win) begin
          if (mcount == 0) begin
            exp_rd = '0; mstat[0] = 1'b1;
          end else begin
            exp_rd = mq[mhead];
            mhead  = (mhead + 1) % DEPTH;
            mcount--;
            if (m_push) both_cnt++;
          end
        end else if (m_ok && req_addr[1:0] == 2'd0) exp_rd = {62'b0, mstat};
        else if (m_ok && req_addr[1:0] == 2'd1)     exp_rd = {62'b0, mmask};
        else exp_rd = '0;
      end
      if (req_valid && req_write) begin
        if (m_win) mstat[1] = 1'b1;
        else if (m_ok && req_addr[1:0] == 2'd0) mstat = mstat & ~req_wdata[1:0];
        else if (m_ok && req_addr[1:0] == 2'd1) mmask = req_wdata[1:0];
      end
      if (m_push) begin
        mq[(mhead + mcount) % DEPTH] = src_data;
        mcount++;
      end
    end
  end

  logic running = 1'b0;
  always @(negedge clk) begin
    if (running && rst_n) chk("R9 irq", {63'b0, irq}, {63'b0, |(mstat & ~mmask)});
  end

  task automatic rd(input logic [AW-1:0] a, input string tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, {63'b0, rsp_valid}, 64'd1);
    chk(tag, rsp_rdata, exp_rd);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R3 watchdog act=hung exp=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; src_valid = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    idle(3);
    chk("R1 irq", {63'b0, irq}, 64'd0);
    chk("R1 rsp_valid", {63'b0, rsp_valid}, 64'd0);
    rst_n = 1'b1;
    running = 1'b1;
    rd(8'h00, "R1 status");
    rd(8'h01, "R1 mask");

    // empty read underflows
    rd(8'h80, "R4 data");
    rd(8'h00, "R4 status");

    // sticky, clear by writing ones only
    wr(8'h00, 64'h2);
    rd(8'h00, "R8 keep");
    wr(8'h00, 64'h1);
    rd(8'h00, "R8 clear");

    // no sampling while source idle
    idle(20);
    rd(8'hC3, "R2 idle");
    wr(8'h00, 64'h3);
    src_valid = 1'b1;
    idle(12);
    rd(8'h9A, "R2 word");
    rd(8'hF0, "R2 word");

    // fill past capacity, drop silently
    idle(60);
    rd(8'h00, "R6 status");
    src_valid = 1'b0;
    for (int i = 0; i < DEPTH; i++) rd(8'h80 | 8'(i * 7), "R11 drain");
    rd(8'hFF, "R11 underflow");
    wr(8'h00, 64'h3);

    // window writes do not touch the queue
    src_valid = 1'b1;
    idle(20);
    src_valid = 1'b0;
    for (int a = 128; a < 256; a++) wr(8'(a), 64'hDEAD_BEEF_0000_0000 | 64'(a));
    rd(8'h00, "R5 status");
    for (int i = 0; i < DEPTH; i++) rd(8'h80 | 8'(i), "R5 data");
    wr(8'h00, 64'h3);

    // mask behaviour
    rd(8'h80, "R9 setup");
    wr(8'h01, 64'h1);
    rd(8'h01, "R9 mask");
    idle(2);
    wr(8'h01, 64'h2);
    idle(2);
    wr(8'h01, 64'h0);
    wr(8'h00, 64'h3);

    // go register and reserved space
    wr(8'h80, 64'h0);
    wr(8'h02, '1);
    rd(8'h02, "R10 go");
    rd(8'h00, "R10 status");
    rd(8'h01, "R10 mask");
    wr(8'h13, 64'h3);
    wr(8'h07, 64'h3);
    rd(8'h00, "R10 reserved write");
    rd(8'h10, "R10 reserved read");
    rd(8'h03, "R10 reserved read");
    wr(8'h00, 64'h3);

    // full address sweep with sampling running
    src_valid = 1'b1;
    idle(45);
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), "R3 sweep");
      if (a % 9 == 0) idle(3);
    end
    for (int a = 128; a < 256; a += 3) rd(8'(a), "R7 overlap");
    chk("R7 overlap seen", {63'b0, both_cnt > 0}, 64'd1);

    idle(2);
    summary();
  end

endmodule